// File: doc/BRIEF.md
# SCSI Bus Controller Register and Interrupt Front End

This block is the host-facing register file of a SCSI bus controller. A host sees sixteen byte-wide register addresses. Most addresses have two separate copies: what the host writes, and what the host reads back. One address is the way into a 16-entry byte FIFO. The block also keeps the status, interrupt-cause and sequence-step registers that report to software. It drives the interrupt line from the pending bit in the status register.

The block carries out the simple commands itself: no-op, FIFO flush, chip reset, bus reset, raise and drop the attention line, and message accepted. It hands the selection and transfer commands to an external sequencer over a valid/ready request channel. A request stays valid, with its command code stable, until the sequencer takes it with ready high on a clock edge. The sequencer reports that a command has finished with a one-cycle done pulse. The pulse carries a bus phase, a step value, a terminal-count flag and interrupt-cause bits, and the block merges these into its read-side registers.

Reset is synchronous. The chip-reset command does the same work as the reset input, on the edge at which the command is written. A host access is a one-cycle strobe (rd or wr) with an address. Read data is combinational from the address while the read strobe is high. A read's side effects, such as a FIFO pop or clearing the interrupt, take place at the clock edge that ends the strobe.

Top module: `scsi_regfront`

## Requirements
- R1: After the reset input, or on the edge at which chip-reset command 0x02 is written, every write-side register is zero except address 14 (0x94), address 9 (0x02) and address 6 (0x05). The read-side count bytes become 0x00, 0x00 and 0x94, and status, interrupt and step read 0x00. The FIFO empties, attention drops, the link indication drops and any pending request is withdrawn.
- R2: Addresses 3 and 8 to 12 read back the last byte written to them. Bits 2:0 of address 8 always read as the fixed controller bus ID, which is 7.
- R3: A write to address 2 pushes a byte into a 16-entry FIFO, and a read of address 2 pops the oldest byte, so bytes come out in the order they went in. A push while the FIFO holds 16 bytes is dropped, and a pop while it is empty leaves the count at zero. Command 0x01 empties the FIFO.
- R4: Address 7 reads as (step value × 32) + FIFO byte count, taken modulo 256.
- R5: When status bit 7 is set, a read of address 5 returns the cause byte. On that edge it zeroes the cause and step registers and sets status to 0x02, the command phase. When status bit 7 is clear, the same read changes nothing.
- R6: The irq output equals status bit 7 as it was one clock earlier.
- R7: Bus-reset command 0x03 sets cause bits 7 (bus reset) and 3 (function complete) and drops the link indication. It sets status bit 7 only when bit 6 of address 8 is clear.
- R8: Message-accepted command 0x12 sets status bit 7 and cause bit 5 (disconnect), sets the step value to 4, leaves the phase field alone and drops the link indication.
- R9: Any write to address 3 clears cause bit 7. A command code that no handler decodes sets status bit 7 and cause bit 6 (illegal command).
- R10: Command 0x1A raises the atn output and command 0x1B drops it.
- R11: Commands 0x10, 0x11, 0x18, 0x41, 0x42, 0x43, 0x44 and 0x46 raise req_valid, with req_cmd set to the full written byte. Both are held until a clock edge sees req_ready high. A sequencer command written while a request is still waiting is dropped and raises the illegal-command cause as in R9.
- R12: A command byte with bit 7 set copies the write-side count bytes at addresses 0, 1 and 14 into their read-side copies and clears status bit 4 (terminal count). Writes to those addresses do not change what the host reads there until such a command arrives.
- R13: A seq_done pulse sets status bit 7 and ORs seq_cause into the cause register. It puts seq_phase into status bits 2:0, using the phase codes data-out 0, data-in 1, command 2, status 3, message-out 6 and message-in 7. It sets status bit 4 when seq_tc is high and loads seq_step into the step register. It drives linked high unless cause bit 5 is set, in which case linked goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from host_addr |
| irq | output | 1 | Interrupt request, level |
| atn | output | 1 | Attention line request to the bus side |
| linked | output | 1 | High while the controller is connected to a target |
| req_valid | output | 1 | Sequencer command request valid |
| req_ready | input | 1 | Sequencer accepts the request |
| req_cmd | output | 8 | Command byte handed to the sequencer |
| seq_done | input | 1 | One-cycle completion pulse from the sequencer |
| seq_phase | input | 3 | Bus phase reported on completion |
| seq_step | input | 3 | Step value reported on completion |
| seq_tc | input | 1 | Terminal count reached |
| seq_cause | input | 8 | Interrupt-cause bits to merge |

## Verification
Two situations are hard to reach from the ports. The first is a second sequencer command arriving while the first still waits for req_ready. The bench holds req_ready low for several cycles and writes another sequencer code, then checks that the held command has not changed and that the illegal cause has appeared. The second is an interrupt-register read with no interrupt pending. Only a bus reset with the report-disable bit set in address 8 produces one, because it sets causes without the status bit. The bench takes that path, and then confirms that repeated reads leave the cause byte and the status byte unchanged.

// File: rtl/scsi_rf_pkg.sv
package scsi_rf_pkg;

  localparam int REG_AW = 4;

  // register addresses
  localparam logic [REG_AW-1:0] A_CNT_LO  = 4'd0;
  localparam logic [REG_AW-1:0] A_CNT_MID = 4'd1;
  localparam logic [REG_AW-1:0] A_FIFO    = 4'd2;
  localparam logic [REG_AW-1:0] A_CMD     = 4'd3;
  localparam logic [REG_AW-1:0] A_STAT    = 4'd4;
  localparam logic [REG_AW-1:0] A_CAUSE   = 4'd5;
  localparam logic [REG_AW-1:0] A_STEP    = 4'd6;
  localparam logic [REG_AW-1:0] A_FLAGS   = 4'd7;
  localparam logic [REG_AW-1:0] A_CONF1   = 4'd8;
  localparam logic [REG_AW-1:0] A_CLKCV   = 4'd9;
  localparam logic [REG_AW-1:0] A_CONF2   = 4'd11;
  localparam logic [REG_AW-1:0] A_CONF3   = 4'd12;
  localparam logic [REG_AW-1:0] A_CNT_HI  = 4'd14;
  localparam logic [REG_AW-1:0] A_SPERIOD = 4'd6;

  // status bits
  localparam int ST_PEND = 7;
  localparam int ST_TC   = 4;

  // cause bits
  localparam int CS_BUSRST = 7;
  localparam int CS_ILL    = 6;
  localparam int CS_DISC   = 5;
  localparam int CS_FDONE  = 3;

  // config-1 bit that suppresses the bus-reset interrupt
  localparam int CF1_NOREP = 6;

  typedef enum logic [2:0] {
    PH_DOUT = 3'd0,
    PH_DIN  = 3'd1,
    PH_CMD  = 3'd2,
    PH_STAT = 3'd3,
    PH_MOUT = 3'd6,
    PH_MIN  = 3'd7
  } bus_phase_e;

  typedef struct packed {
    logic nop;
    logic flush;
    logic chip_rst;
    logic bus_rst;
    logic atn_on;
    logic atn_off;
    logic msg_ok;
    logic seq;
    logic illegal;
    logic dma;
  } cmd_class_t;

endpackage

// File: rtl/scsi_rf_cmddec.sv
module scsi_rf_cmddec
  import scsi_rf_pkg::*;
(
  input  logic [7:0] code,
  output cmd_class_t cls
);
  always_comb begin
    cls     = '0;
    cls.dma = code[7];
    case (code[6:0])
      7'h00: cls.nop      = 1'b1;
      7'h01: cls.flush    = 1'b1;
      7'h02: cls.chip_rst = 1'b1;
      7'h03: cls.bus_rst  = 1'b1;
      7'h12: cls.msg_ok   = 1'b1;
      7'h1A: cls.atn_on   = 1'b1;
      7'h1B: cls.atn_off  = 1'b1;
      7'h10, 7'h11, 7'h18,
      7'h41, 7'h42, 7'h43, 7'h44, 7'h46: cls.seq = 1'b1;
      default: cls.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/scsi_rf_fifo.sv
module scsi_rf_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_push, do_pop;

  assign do_push = push && (count != FULL);
  assign do_pop  = pop  && (count != '0);
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  assert_fifo_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && !flush && count == FULL |=> count == FULL);
  assert_fifo_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && !flush && count == '0 |=> count == '0);
endmodule

// File: rtl/scsi_regfront.sv
module scsi_regfront
  import scsi_rf_pkg::*;
#(
  parameter int          FIFO_DEPTH = 16,
  parameter logic [2:0]  BUS_ID     = 3'd7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_rd,
  input  logic       host_wr,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq,
  output logic       atn,
  output logic       linked,
  output logic       req_valid,
  input  logic       req_ready,
  output logic [7:0] req_cmd,
  input  logic       seq_done,
  input  logic [2:0] seq_phase,
  input  logic [2:0] seq_step,
  input  logic       seq_tc,
  input  logic [7:0] seq_cause
);
  localparam int NREG  = 1 << REG_AW;
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);

  logic [7:0]       wr_q [NREG];
  logic [7:0]       cnt_lo_q, cnt_mid_q, cnt_hi_q;
  logic [7:0]       stat_q, cause_q;
  logic [2:0]       step_q;
  logic             atn_q, link_q, reqv_q, irq_q;
  logic [7:0]       reqc_q;

  logic [7:0]       cnt_lo_n, cnt_mid_n, cnt_hi_n, stat_n, cause_n, reqc_n;
  logic [2:0]       step_n;
  logic             atn_n, link_n, reqv_n;

  cmd_class_t       cls;
  logic             cmd_wr, soft_clr, cause_rd;
  logic [7:0]       fifo_head;
  logic [CNT_W-1:0] fifo_cnt;

  assign cmd_wr   = host_wr && (host_addr == A_CMD);
  assign soft_clr = cmd_wr && cls.chip_rst;
  assign cause_rd = host_rd && (host_addr == A_CAUSE);

  scsi_rf_cmddec u_dec (
    .code (host_wdata),
    .cls  (cls)
  );

  scsi_rf_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (cmd_wr && (cls.flush || cls.chip_rst)),
    .push      (host_wr && (host_addr == A_FIFO)),
    .push_data (host_wdata),
    .pop       (host_rd && (host_addr == A_FIFO)),
    .head      (fifo_head),
    .count     (fifo_cnt)
  );

  // next-state of the read-side registers
  always_comb begin
    stat_n    = stat_q;
    cause_n   = cause_q;
    step_n    = step_q;
    cnt_lo_n  = cnt_lo_q;
    cnt_mid_n = cnt_mid_q;
    cnt_hi_n  = cnt_hi_q;
    atn_n     = atn_q;
    link_n    = link_q;
    reqv_n    = reqv_q;
    reqc_n    = reqc_q;

    if (reqv_q && req_ready) reqv_n = 1'b0;

    if (seq_done) begin
      stat_n[ST_PEND] = 1'b1;
      if (seq_tc) stat_n[ST_TC] = 1'b1;
      stat_n[2:0]     = seq_phase;
      cause_n         = cause_q | seq_cause;
      step_n          = seq_step;
      link_n          = !seq_cause[CS_DISC];
    end

    if (cause_rd && stat_q[ST_PEND]) begin
      cause_n = '0;
      step_n  = '0;
      stat_n  = {5'b0, PH_CMD};
    end

    if (cmd_wr) begin
      cause_n[CS_BUSRST] = 1'b0;
      if (cls.dma) begin
        cnt_lo_n      = wr_q[A_CNT_LO];
        cnt_mid_n     = wr_q[A_CNT_MID];
        cnt_hi_n      = wr_q[A_CNT_HI];
        stat_n[ST_TC] = 1'b0;
      end
      if (cls.bus_rst) begin
        if (!wr_q[A_CONF1][CF1_NOREP]) stat_n[ST_PEND] = 1'b1;
        cause_n[CS_BUSRST] = 1'b1;
        cause_n[CS_FDONE]  = 1'b1;
        link_n             = 1'b0;
      end
      if (cls.atn_on)  atn_n = 1'b1;
      if (cls.atn_off) atn_n = 1'b0;
      if (cls.msg_ok) begin
        stat_n[ST_PEND]  = 1'b1;
        cause_n[CS_DISC] = 1'b1;
        step_n           = 3'd4;
        link_n           = 1'b0;
      end
      if (cls.seq) begin
        if (reqv_q && !req_ready) begin
          stat_n[ST_PEND] = 1'b1;
          cause_n[CS_ILL] = 1'b1;
        end else begin
          reqv_n = 1'b1;
          reqc_n = host_wdata;
        end
      end
      if (cls.illegal) begin
        stat_n[ST_PEND] = 1'b1;
        cause_n[CS_ILL] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_clr) begin
      for (int i = 0; i < NREG; i++) wr_q[i] <= '0;
      wr_q[A_CNT_HI]  <= 8'h94;
      wr_q[A_CLKCV]   <= 8'h02;
      wr_q[A_SPERIOD] <= 8'h05;
      cnt_lo_q  <= '0;
      cnt_mid_q <= '0;
      cnt_hi_q  <= 8'h94;
      stat_q    <= '0;
      cause_q   <= '0;
      step_q    <= '0;
      atn_q     <= 1'b0;
      link_q    <= 1'b0;
      reqv_q    <= 1'b0;
      reqc_q    <= '0;
    end else begin
      if (host_wr && host_addr != A_FIFO) wr_q[host_addr] <= host_wdata;
      cnt_lo_q  <= cnt_lo_n;
      cnt_mid_q <= cnt_mid_n;
      cnt_hi_q  <= cnt_hi_n;
      stat_q    <= stat_n;
      cause_q   <= cause_n;
      step_q    <= step_n;
      atn_q     <= atn_n;
      link_q    <= link_n;
      reqv_q    <= reqv_n;
      reqc_q    <= reqc_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= stat_q[ST_PEND];
  end

  always_comb begin
    case (host_addr)
      A_CNT_LO:  host_rdata = cnt_lo_q;
      A_CNT_MID: host_rdata = cnt_mid_q;
      A_FIFO:    host_rdata = fifo_head;
      A_CMD:     host_rdata = wr_q[A_CMD];
      A_STAT:    host_rdata = stat_q;
      A_CAUSE:   host_rdata = cause_q;
      A_STEP:    host_rdata = {5'b0, step_q};
      A_FLAGS:   host_rdata = {step_q, 5'b0} + 8'(fifo_cnt);
      A_CONF1:   host_rdata = {wr_q[A_CONF1][7:3], BUS_ID};
      A_CLKCV, 4'd10, A_CONF2, A_CONF3:
                 host_rdata = wr_q[host_addr];
      A_CNT_HI:  host_rdata = cnt_hi_q;
      default:   host_rdata = 8'h00;
    endcase
  end

  assign irq       = irq_q;
  assign atn       = atn_q;
  assign linked    = link_q;
  assign req_valid = reqv_q;
  assign req_cmd   = reqc_q;

  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[ST_PEND] |=> irq);
  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[ST_PEND] |=> !irq);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !soft_clr |=> req_valid && $stable(req_cmd));
  assert_cause_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cause_rd && stat_q[ST_PEND] && !seq_done |=> stat_q == 8'h02 && cause_q == 8'h00);
  assert_busrst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cls.bus_rst |=> cause_q[CS_BUSRST] && cause_q[CS_FDONE] && !linked);
  assert_msgok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cls.msg_ok && !seq_done |=> stat_q[ST_PEND] && step_q == 3'd4 && !linked);
  assert_one_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> $onehot0({cls.nop, cls.flush, cls.chip_rst, cls.bus_rst, cls.atn_on,
                         cls.atn_off, cls.msg_ok, cls.seq, cls.illegal}));
endmodule

// File: tb/tb_scsi_regfront.sv
module tb_scsi_regfront;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq, atn, linked, req_valid;
  logic       req_ready = 1'b0;
  logic [7:0] req_cmd;
  logic       seq_done = 1'b0;
  logic [2:0] seq_phase = '0, seq_step = '0;
  logic       seq_tc = 1'b0;
  logic [7:0] seq_cause = '0;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_regfront dut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .atn(atn), .linked(linked), .req_valid(req_valid),
    .req_ready(req_ready), .req_cmd(req_cmd), .seq_done(seq_done),
    .seq_phase(seq_phase), .seq_step(seq_step), .seq_tc(seq_tc),
    .seq_cause(seq_cause)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 check(tag, host_rdata, exp);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic done_pulse(input logic [2:0] ph, input logic [2:0] st,
                            input logic tc, input logic [7:0] cs);
    @(negedge clk);
    seq_done = 1'b1; seq_phase = ph; seq_step = st; seq_tc = tc; seq_cause = cs;
    @(negedge clk);
    seq_done = 1'b0; seq_tc = 1'b0; seq_cause = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog R1..: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    hrd(4, 8'h00, "R1 status");
    hrd(5, 8'h00, "R1 cause");
    hrd(6, 8'h00, "R1 step");
    hrd(7, 8'h00, "R1 flags");
    hrd(14, 8'h94, "R1 count hi");
    hrd(9, 8'h02, "R1 clock conv");
    hrd(0, 8'h00, "R1 count lo");
    hrd(1, 8'h00, "R1 count mid");
    hrd(3, 8'h00, "R1 command");
    hrd(8, 8'h07, "R2 bus id after reset");
    check("R1 irq", irq, 0);
    check("R1 atn", atn, 0);
    check("R1 req_valid", req_valid, 0);
    check("R1 linked", linked, 0);

    // R2 sweep of readback registers
    for (int a = 8; a <= 12; a++) begin
      for (int v = 0; v < 256; v++) begin
        hwr(4'(a), 8'(v));
        if (a == 8) hrd(4'(a), {8'(v) & 8'hF8} | 8'h07, "R2 conf1 readback");
        else        hrd(4'(a), 8'(v), "R2 readback");
      end
    end
    hwr(8, 8'h00);
    hwr(3, 8'h00);
    hrd(3, 8'h00, "R2 command readback nop");

    // R10 attention
    hwr(3, 8'h1A);
    check("R10 atn on", atn, 1);
    hrd(3, 8'h1A, "R2 command readback");
    hwr(3, 8'h1B);
    check("R10 atn off", atn, 0);

    // R3 / R4 FIFO sweep
    for (int i = 0; i < 17; i++) begin
      hwr(2, 8'(8'h30 + i));
      hrd(7, 8'((i + 1 > 16) ? 16 : i + 1), "R4 flags count");
    end
    for (int i = 0; i < 16; i++) hrd(2, 8'(8'h30 + i), "R3 fifo order");
    hrd(7, 8'h00, "R3 fifo empty");
    @(negedge clk); host_rd = 1'b1; host_addr = 2; @(negedge clk); host_rd = 1'b0;
    hrd(7, 8'h00, "R3 pop on empty");
    for (int i = 0; i < 3; i++) hwr(2, 8'(i));
    hrd(7, 8'h03, "R4 three bytes");
    hwr(3, 8'h01);
    hrd(7, 8'h00, "R3 flush");
    hwr(2, 8'hA1); hwr(2, 8'hA2);

    // R7 bus reset, report enabled; R6 irq delay; R5 clear
    hwr(3, 8'h03);
    check("R6 irq one cycle late", irq, 0);
    @(negedge clk);
    check("R6 irq raised", irq, 1);
    check("R7 linked low", linked, 0);
    hrd(4, 8'h80, "R7 status pending");
    hrd(5, 8'h88, "R7 cause");
    hrd(4, 8'h02, "R5 status after clear");
    hrd(5, 8'h00, "R5 cause cleared");
    hrd(6, 8'h00, "R5 step cleared");
    check("R6 irq dropped", irq, 0);

    // R7 report disabled; R5 read without pending
    hwr(8, 8'h40);
    hwr(3, 8'h03);
    hrd(4, 8'h02, "R7 no pending bit");
    hrd(5, 8'h88, "R7 cause still set");
    hrd(5, 8'h88, "R5 read without pending no effect");
    hrd(4, 8'h02, "R5 status untouched");
    check("R6 irq stays low", irq, 0);
    hwr(3, 8'h00);
    hrd(5, 8'h08, "R9 command clears bus reset cause");
    hwr(8, 8'h00);

    // R9 illegal command
    hwr(3, 8'h05);
    hrd(4, 8'h82, "R9 illegal pending");
    hrd(5, 8'h48, "R9 illegal cause");
    hrd(4, 8'h02, "R5 cleared after illegal");

    // R13 completion merging
    done_pulse(3'd1, 3'd3, 1'b1, 8'h18);
    hrd(4, 8'h91, "R13 status phase data-in tc");
    hrd(6, 8'h03, "R13 step");
    hrd(7, 8'h62, "R4 flags with step");
    check("R13 linked", linked, 1);
    hrd(5, 8'h18, "R13 cause");
    done_pulse(3'd6, 3'd0, 1'b0, 8'h20);
    hrd(4, 8'h86, "R13 message-out phase");
    check("R13 disconnect unlinks", linked, 0);
    hrd(5, 8'h20, "R13 cause disc");
    done_pulse(3'd7, 3'd2, 1'b0, 8'h08);
    hrd(4, 8'h87, "R13 message-in phase");
    check("R13 relinked", linked, 1);
    hrd(5, 8'h08, "R13 cause fc");

    // R8 message accepted
    hwr(3, 8'h12);
    hrd(4, 8'h82, "R8 status phase kept");
    hrd(6, 8'h04, "R8 step");
    hrd(7, 8'h82, "R4 flags step 4");
    check("R8 unlinked", linked, 0);
    hrd(5, 8'h20, "R8 cause disc");

    // R12 DMA count load
    done_pulse(3'd0, 3'd0, 1'b1, 8'h10);
    hwr(0, 8'h34); hwr(1, 8'h12); hwr(14, 8'h56);
    hrd(0, 8'h00, "R12 count lo before load");
    hrd(14, 8'h94, "R12 count hi before load");
    hrd(4, 8'h90, "R12 tc set");
    hwr(3, 8'h80);
    hrd(0, 8'h34, "R12 count lo");
    hrd(1, 8'h12, "R12 count mid");
    hrd(14, 8'h56, "R12 count hi");
    hrd(4, 8'h80, "R12 tc cleared");
    hrd(5, 8'h10, "R12 cause");

    // R11 sequencer request
    hwr(3, 8'h42);
    for (int i = 0; i < 3; i++) begin
      check("R11 valid held", req_valid, 1);
      check("R11 cmd held", req_cmd, 8'h42);
      @(negedge clk);
    end
    hwr(3, 8'h10);
    check("R11 cmd kept on second", req_cmd, 8'h42);
    hrd(5, 8'h40, "R11 second command illegal");
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    check("R11 accepted", req_valid, 0);
    hwr(3, 8'hC1);
    check("R11 dma select", req_cmd, 8'hC1);
    check("R11 dma valid", req_valid, 1);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    check("R11 dma accepted", req_valid, 0);

    // R1 chip reset command
    hwr(3, 8'h1A);
    hwr(9, 8'h55);
    hwr(2, 8'h11);
    hwr(3, 8'h43);
    check("R1 pre pending", req_valid, 1);
    hwr(3, 8'h02);
    check("R1 chip reset drops request", req_valid, 0);
    check("R1 chip reset atn", atn, 0);
    hrd(9, 8'h02, "R1 chip reset clock conv");
    hrd(14, 8'h94, "R1 chip reset count hi");
    hrd(0, 8'h00, "R1 chip reset count lo");
    hrd(7, 8'h00, "R1 chip reset fifo");
    hrd(4, 8'h00, "R1 chip reset status");
    hrd(5, 8'h00, "R1 chip reset cause");
    hrd(3, 8'h00, "R1 chip reset command");
    hrd(8, 8'h07, "R2 bus id after chip reset");

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule